// File: doc/BRIEF.md
# Read-Calibration Pattern-Mode Sequencer

This controller-side sequencer puts a DRAM device into its predefined-pattern read mode, issues a programmable number of calibration reads, and takes the device out of that mode again. A single start pulse runs the whole procedure. The command order is fixed: precharge all banks, write mode register 3 to enable pattern reads, issue the reads, then write mode register 3 again to disable them. Between each pair of commands the block counts the idle cycles that the programmed timing values require.

The timing values and the read count are captured when a start is accepted. A later change on those inputs has no effect on the run in progress. While pattern mode is enabled, a write-inhibit flag tells the rest of the controller that no write command may be sent. A one-cycle done pulse marks the point where the device is back in normal mode and ready for traffic. Capturing the returned pattern and tuning the read delay belong to other blocks.

Top module: `cal_pattern_seq`

## Requirements
- R1: Command encoding is NOP=2'b00, PRECHARGE-ALL=2'b01, MODE-REGISTER-WRITE=2'b10, READ=2'b11. When start is high in idle, precharge-all appears on `cmd` in the next cycle, and `busy` is high from that cycle on.
- R2: After precharge-all, exactly max(t_rp,1) NOP cycles pass before the entry mode-register write.
- R3: The entry mode-register write drives `cmd_mr`=3 and `cmd_addr` with bit 2 set and all other bits clear (bits [1:0]=00).
- R4: The first read follows the entry write after exactly max(t_mrd,t_mod,1) NOP cycles.
- R5: `write_inhibit` rises in the cycle after the entry write and stays high until the done cycle, when it is low. Every read occurs while it is high.
- R6: Exactly max(rd_count,1) reads are issued, each with `cmd_addr`=0. Consecutive reads are max(t_rd_gap,4) cycles apart, counted command to command.
- R7: After the last read, exactly max(t_exit_rd,1) NOP cycles pass before the exit mode-register write. That write drives `cmd_mr`=3 and `cmd_addr`=0.
- R8: `done` is high for exactly one cycle, after max(t_mod,1) NOP cycles following the exit write. `busy` is low in that cycle.
- R9: A start pulse while `busy` is high is ignored: no second precharge-all is issued and the run's timing is unchanged.
- R10: During and after reset, `cmd`=NOP, `cmd_addr`=0, `cmd_mr`=0, and `busy`, `done` and `write_inhibit` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to run the calibration sequence |
| t_rp | input | TW | Idle cycles after precharge-all |
| t_mrd | input | TW | Mode-register-write recovery cycles |
| t_mod | input | TW | Mode-register-write to next command cycles |
| t_rd_gap | input | TW | Read command-to-command spacing (minimum 4) |
| t_exit_rd | input | TW | Idle cycles from last read to exit write |
| rd_count | input | CW | Number of calibration reads (0 treated as 1) |
| cmd | output | 2 | Command code |
| cmd_addr | output | ADDR_W | Address bits sent with the command |
| cmd_mr | output | 2 | Mode-register select for mode-register writes |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| write_inhibit | output | 1 | Writes forbidden while pattern mode is on |

## Verification
Some properties hold on every cycle, and the bound checker watches them:
- each run opens with precharge-all, and a precharge-all never follows a busy cycle;
- each mode-register write carries the correct code, with entry and exit told apart by the inhibit flag;
- a read is never issued without the inhibit flag;
- reads are never closer than four cycles apart;
- done is a lone pulse that coincides with busy low.

The exact idle-cycle counts between commands, the read count, the clamping of zero or small settings, and the absence of any effect from a start pulse during a run depend on the programmed values. Only the bench scenarios, which compare event cycles against values computed from the settings, can show those.

// File: rtl/cal_pattern_seq_pkg.sv
package cal_pattern_seq_pkg;

   typedef enum logic [1:0] {
      CMD_NOP  = 2'b00,
      CMD_PREA = 2'b01,
      CMD_MRW  = 2'b10,
      CMD_RD   = 2'b11
   } cal_cmd_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PREA,
      ST_W_RP,
      ST_MRW_ON,
      ST_W_MOD,
      ST_RD,
      ST_W_GAP,
      ST_W_EXITRD,
      ST_MRW_OFF,
      ST_W_EXIT
   } cal_state_e;

   localparam logic [1:0] PAT_MR_SEL  = 2'd3;
   localparam int         PAT_EN_BIT  = 2;
   localparam int         MIN_RD_GAP  = 4;

endpackage

// File: rtl/cal_wait_select.sv
module cal_wait_select
   import cal_pattern_seq_pkg::*;
#(
   parameter int TW = 8,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capture,
   input  logic [TW-1:0] t_rp,
   input  logic [TW-1:0] t_mrd,
   input  logic [TW-1:0] t_mod,
   input  logic [TW-1:0] t_rd_gap,
   input  logic [TW-1:0] t_exit_rd,
   input  logic [CW-1:0] rd_count,
   output logic [TW-1:0] ld_rp,
   output logic [TW-1:0] ld_mod,
   output logic [TW-1:0] ld_gap,
   output logic [TW-1:0] ld_exitrd,
   output logic [TW-1:0] ld_exit,
   output logic [CW-1:0] rd_total
);

   localparam logic [TW-1:0] ONE_T   = TW'(1);
   localparam logic [TW-1:0] GAP_MIN = TW'(MIN_RD_GAP);
   localparam logic [CW-1:0] ONE_C   = CW'(1);

   function automatic logic [TW-1:0] atleast(input logic [TW-1:0] v,
                                             input logic [TW-1:0] lo);
      return (v < lo) ? lo : v;
   endfunction

   logic [TW-1:0] mod_wait;
   assign mod_wait = (t_mrd > t_mod) ? t_mrd : t_mod;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_rp     <= '0;
         ld_mod    <= '0;
         ld_gap    <= '0;
         ld_exitrd <= '0;
         ld_exit   <= '0;
         rd_total  <= ONE_C;
      end else if (capture) begin
         ld_rp     <= atleast(t_rp, ONE_T) - ONE_T;
         ld_mod    <= atleast(mod_wait, ONE_T) - ONE_T;
         ld_gap    <= atleast(t_rd_gap, GAP_MIN) - ONE_T - ONE_T;
         ld_exitrd <= atleast(t_exit_rd, ONE_T) - ONE_T;
         ld_exit   <= atleast(t_mod, ONE_T) - ONE_T;
         rd_total  <= (rd_count == '0) ? ONE_C : rd_count;
      end
   end

endmodule

// File: rtl/cal_wait_timer.sv
module cal_wait_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt <= '0;
      else if (load)            cnt <= load_val;
      else if (cnt != '0)       cnt <= cnt - TW'(1);
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/cal_read_counter.sv
module cal_read_counter #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] total,
   input  logic          issue,
   output logic          last
);

   logic [CW-1:0] left;

   always_ff @(posedge clk) begin
      if (!rst_n)                    left <= '0;
      else if (load)                 left <= total;
      else if (issue && left != '0)  left <= left - CW'(1);
   end

   assign last = (left <= CW'(1));

endmodule

// File: rtl/cal_pattern_seq.sv
module cal_pattern_seq
   import cal_pattern_seq_pkg::*;
#(
   parameter int TW     = 8,
   parameter int CW     = 8,
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [TW-1:0]     t_rp,
   input  logic [TW-1:0]     t_mrd,
   input  logic [TW-1:0]     t_mod,
   input  logic [TW-1:0]     t_rd_gap,
   input  logic [TW-1:0]     t_exit_rd,
   input  logic [CW-1:0]     rd_count,
   output logic [1:0]        cmd,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [1:0]        cmd_mr,
   output logic              busy,
   output logic              done,
   output logic              write_inhibit
);

   if (TW < 3) begin : g_chk_tw
      $error("cal_pattern_seq: TW must be at least 3");
   end
   if (CW < 1) begin : g_chk_cw
      $error("cal_pattern_seq: CW must be at least 1");
   end
   if (ADDR_W <= PAT_EN_BIT) begin : g_chk_aw
      $error("cal_pattern_seq: ADDR_W too small for the pattern enable bit");
   end

   cal_state_e    st, st_nxt;
   logic          accept;
   logic          t_load, t_done;
   logic [TW-1:0] t_val;
   logic          rd_last, rd_issue;
   logic          finish;
   logic [TW-1:0] ld_rp, ld_mod, ld_gap, ld_exitrd, ld_exit;
   logic [CW-1:0] rd_total;
   logic          done_q, inhibit_q;

   assign accept   = (st == ST_IDLE) && start;
   assign rd_issue = (st == ST_RD);

   cal_wait_select #(.TW(TW), .CW(CW)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (accept),
      .t_rp      (t_rp),
      .t_mrd     (t_mrd),
      .t_mod     (t_mod),
      .t_rd_gap  (t_rd_gap),
      .t_exit_rd (t_exit_rd),
      .rd_count  (rd_count),
      .ld_rp     (ld_rp),
      .ld_mod    (ld_mod),
      .ld_gap    (ld_gap),
      .ld_exitrd (ld_exitrd),
      .ld_exit   (ld_exit),
      .rd_total  (rd_total)
   );

   cal_wait_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_done)
   );

   cal_read_counter #(.CW(CW)) u_rdcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (st == ST_PREA),
      .total (rd_total),
      .issue (rd_issue),
      .last  (rd_last)
   );

   always_comb begin
      st_nxt = st;
      t_load = 1'b0;
      t_val  = '0;
      finish = 1'b0;
      unique case (st)
         ST_IDLE:     if (start) st_nxt = ST_PREA;
         ST_PREA: begin
            st_nxt = ST_W_RP;
            t_load = 1'b1;
            t_val  = ld_rp;
         end
         ST_W_RP:     if (t_done) st_nxt = ST_MRW_ON;
         ST_MRW_ON: begin
            st_nxt = ST_W_MOD;
            t_load = 1'b1;
            t_val  = ld_mod;
         end
         ST_W_MOD:    if (t_done) st_nxt = ST_RD;
         ST_RD: begin
            t_load = 1'b1;
            if (rd_last) begin
               st_nxt = ST_W_EXITRD;
               t_val  = ld_exitrd;
            end else begin
               st_nxt = ST_W_GAP;
               t_val  = ld_gap;
            end
         end
         ST_W_GAP:    if (t_done) st_nxt = ST_RD;
         ST_W_EXITRD: if (t_done) st_nxt = ST_MRW_OFF;
         ST_MRW_OFF: begin
            st_nxt = ST_W_EXIT;
            t_load = 1'b1;
            t_val  = ld_exit;
         end
         ST_W_EXIT: begin
            if (t_done) begin
               st_nxt = ST_IDLE;
               finish = 1'b1;
            end
         end
         default:     st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         done_q    <= 1'b0;
         inhibit_q <= 1'b0;
      end else begin
         st     <= st_nxt;
         done_q <= finish;
         if (st == ST_MRW_ON) inhibit_q <= 1'b1;
         else if (finish)     inhibit_q <= 1'b0;
      end
   end

   // Address pattern: only the enable bit differs between entry and exit.
   logic [ADDR_W-1:0] addr_bits;
   for (genvar i = 0; i < ADDR_W; i++) begin : g_addr
      if (i == PAT_EN_BIT) begin : g_en
         assign addr_bits[i] = (st == ST_MRW_ON);
      end else begin : g_zero
         assign addr_bits[i] = 1'b0;
      end
   end

   always_comb begin
      unique case (st)
         ST_PREA:               cmd = CMD_PREA;
         ST_MRW_ON, ST_MRW_OFF: cmd = CMD_MRW;
         ST_RD:                 cmd = CMD_RD;
         default:               cmd = CMD_NOP;
      endcase
   end

   assign cmd_addr      = addr_bits;
   assign cmd_mr        = (st == ST_MRW_ON || st == ST_MRW_OFF) ? PAT_MR_SEL : 2'd0;
   assign busy          = (st != ST_IDLE);
   assign done          = done_q;
   assign write_inhibit = inhibit_q;

endmodule

// File: rtl/cal_pattern_seq_chk.sv
module cal_pattern_seq_chk #(
   parameter int ADDR_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [1:0]        cmd,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic [1:0]        cmd_mr,
   input logic              busy,
   input logic              done,
   input logic              write_inhibit
);

   logic [2:0] since_rd;
   logic       seen_rd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_rd <= '0;
         seen_rd  <= 1'b0;
      end else if (cmd == 2'b11) begin
         since_rd <= 3'd1;
         seen_rd  <= 1'b1;
      end else if (!busy) begin
         seen_rd  <= 1'b0;
         since_rd <= '0;
      end else if (since_rd != 3'd7) begin
         since_rd <= since_rd + 3'd1;
      end
   end

   p_open_prea_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> cmd == 2'b01);

   p_prea_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == 2'b01 |-> !$past(busy));

   p_entry_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 2'b10 && !write_inhibit) |-> (cmd_mr == 2'd3 && cmd_addr == ADDR_W'(4)));

   p_exit_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 2'b10 && write_inhibit) |-> (cmd_mr == 2'd3 && cmd_addr == '0));

   p_read_inhibited_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == 2'b11 |-> (write_inhibit && cmd_addr == '0));

   p_read_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 2'b11 && seen_rd) |-> since_rd >= 3'd4);

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !write_inhibit) ##1 !done);

   p_reset_quiet_r10: assert property (@(posedge clk)
      !rst_n |=> (!rst_n |-> (cmd == 2'b00 && !busy && !done && !write_inhibit)));

endmodule

bind cal_pattern_seq cal_pattern_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start         (start),
   .cmd           (cmd),
   .cmd_addr      (cmd_addr),
   .cmd_mr        (cmd_mr),
   .busy          (busy),
   .done          (done),
   .write_inhibit (write_inhibit)
);

// File: tb/cal_pattern_seq_test.sv
module cal_pattern_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int TW = 8;
   localparam int CW = 8;
   localparam int AW = 14;
   localparam int NVEC = 4;

   // {t_rp, t_mrd, t_mod, t_rd_gap, t_exit_rd, rd_count}
   localparam logic [47:0] VECS [NVEC] = '{
      {8'd3, 8'd4,  8'd12, 8'd4, 8'd2, 8'd3},
      {8'd5, 8'd10, 8'd2,  8'd6, 8'd1, 8'd1},
      {8'd0, 8'd0,  8'd0,  8'd1, 8'd0, 8'd0},
      {8'd2, 8'd7,  8'd7,  8'd9, 8'd3, 8'd5}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [TW-1:0] t_rp = '0, t_mrd = '0, t_mod = '0, t_rd_gap = '0, t_exit_rd = '0;
   logic [CW-1:0] rd_count = '0;
   logic [1:0] cmd, cmd_mr;
   logic [AW-1:0] cmd_addr;
   logic busy, done, write_inhibit;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cal_pattern_seq #(.TW(TW), .CW(CW), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .t_rp(t_rp), .t_mrd(t_mrd), .t_mod(t_mod), .t_rd_gap(t_rd_gap),
      .t_exit_rd(t_exit_rd), .rd_count(rd_count),
      .cmd(cmd), .cmd_addr(cmd_addr), .cmd_mr(cmd_mr),
      .busy(busy), .done(done), .write_inhibit(write_inhibit)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic run_one(input logic [47:0] v, input bit poke);
      int trp, w, g, prr, tm, n;
      int e_on, e_rd1, e_rdl, e_off, e_dn;
      int c_prea, n_prea, c_on, a_on, c_rd1, c_rdl, n_rd, min_sp, c_off, a_off, c_dn;
      int wi_cnt, busy_dn, bad_addr;
      trp = mx(int'(v[47:40]), 1);
      w   = mx(mx(int'(v[39:32]), int'(v[31:24])), 1);
      g   = mx(int'(v[23:16]), 4);
      prr = mx(int'(v[15:8]), 1);
      tm  = mx(int'(v[31:24]), 1);
      n   = mx(int'(v[7:0]), 1);
      e_on  = 1 + trp;
      e_rd1 = e_on + 1 + w;
      e_rdl = e_rd1 + (n - 1) * g;
      e_off = e_rdl + 1 + prr;
      e_dn  = e_off + 1 + tm;
      c_prea = -1; n_prea = 0; c_on = -1; a_on = -1; c_rd1 = -1; c_rdl = -1;
      n_rd = 0; min_sp = 999; c_off = -1; a_off = -1; c_dn = -1;
      wi_cnt = 0; busy_dn = -1; bad_addr = 0;
      @(negedge clk);
      {t_rp, t_mrd, t_mod, t_rd_gap, t_exit_rd, rd_count} = v;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int cyc = 0; cyc < 3000; cyc++) begin
         if (cmd == 2'b01) begin n_prea++; if (c_prea < 0) c_prea = cyc; end
         if (cmd == 2'b10 && c_on < 0) begin c_on = cyc; a_on = int'(cmd_addr); end
         else if (cmd == 2'b10) begin c_off = cyc; a_off = int'(cmd_addr); end
         if (cmd == 2'b11) begin
            if (c_rdl >= 0) min_sp = (cyc - c_rdl < min_sp) ? cyc - c_rdl : min_sp;
            if (c_rd1 < 0) c_rd1 = cyc;
            c_rdl = cyc; n_rd++;
            if (cmd_addr != '0) bad_addr++;
         end
         if (write_inhibit) wi_cnt++;
         if (done) begin c_dn = cyc; busy_dn = int'(busy); break; end
         if (poke) begin
            start = (cyc == 4) ? 1'b1 : 1'b0;
            if (cyc == 4) {t_rp, t_mrd} = 16'hFFFF;
         end
         @(negedge clk);
      end
      start = 1'b0;
      check("R1 prea cycle", c_prea, 0);
      check("R9 single prea", n_prea, 1);
      check("R2 entry write cycle", c_on, e_on);
      check("R3 entry address", a_on, 4);
      check("R4 first read cycle", c_rd1, e_rd1);
      check("R6 read count", n_rd, n);
      check("R6 last read cycle", c_rdl, e_rdl);
      check("R6 read address", bad_addr, 0);
      if (n > 1) check("R6 read spacing", min_sp, g);
      check("R7 exit write cycle", c_off, e_off);
      check("R7 exit address", a_off, 0);
      check("R8 done cycle", c_dn, e_dn);
      check("R8 busy low at done", busy_dn, 0);
      check("R5 inhibit length", wi_cnt, e_dn - e_on - 1);
      @(negedge clk);
      check("R8 done one cycle", int'(done), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: outputs quiet while in reset, even with start high
      start = 1'b1;
      @(negedge clk);
      check("R10 cmd in reset", int'(cmd), 0);
      check("R10 busy in reset", int'(busy), 0);
      check("R10 flags in reset", int'({done, write_inhibit}), 0);
      check("R10 addr in reset", int'(cmd_addr) + int'(cmd_mr), 0);
      start = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 idle after reset", int'(busy), 0);

      for (int i = 0; i < NVEC; i++) run_one(VECS[i], 1'b0);

      // R9: start pulse and input change mid-run must not disturb timing
      run_one(VECS[0], 1'b1);

      // R10: reset in the middle of a run returns to quiet outputs
      @(negedge clk);
      {t_rp, t_mrd, t_mod, t_rd_gap, t_exit_rd, rd_count} = VECS[3];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (8) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 cmd after mid-run reset", int'(cmd), 0);
      check("R10 inhibit after mid-run reset", int'(write_inhibit), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 busy after mid-run reset", int'(busy), 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule